// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Programmable Bit-Rate Divider

This block is a full-duplex asynchronous serial port. It has a transmitter and a receiver that work independently of each other. Both take their bit timing from one shared rate generator. The generator counts the core clock down by a 16-bit divisor and emits one oversampling tick every `cfg_div` clocks. Each bit on the line lasts sixteen such ticks, so the bit period is 16 × `cfg_div` core clocks. The fastest rate is therefore one sixteenth of the clock, and the slowest is the clock divided by 16 × 65535. A divisor of zero stops the ticks and holds both directions idle.

Characters always carry eight data bits. On the line a character is sent as a low start bit, then the data bits least-significant first, then an optional parity bit, then one high stop bit. A new character may follow the stop bit of the previous one with no guard time. The receiver re-times the line through two flops and oversamples it sixteen times per bit. It keeps the received byte until it is acknowledged, and it raises sticky flags for parity, framing and overrun errors. There is no receive timeout and no clock pin.

Top module: `uart_xcvr`

## Requirements
- R1: The line bit period is exactly 16 × `cfg_div` core clocks, for any non-zero divisor.
- R2: While `cfg_div` is 0, `txd` stays high, `tx_ready` stays low, and activity on `rxd` never raises `rx_valid` or an error flag.
- R3: A transmitted frame has the following layout on `txd`:
  - a start bit of 0;
  - `tx_data[0]` through `tx_data[7]`;
  - a parity bit when `cfg_par` selects one;
  - a stop bit of 1.

  The `cfg_par` encoding is:

  | `cfg_par` | Parity bit |
  |---|---|
  | 0 | none |
  | 1 | even (XOR of the data) |
  | 2 | odd (inverse XOR) |
  | 3 | constant 0 |
  | 4 | constant 1 |
  | 5 to 7 | none |
- R4: A byte is accepted on a clock where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the frame's stop bit has ended.
- R5: With a byte waiting, the next start bit follows the previous stop bit with no guard time. Start bits are (9 + P + 1) × 16 × `cfg_div` clocks apart within ±(2 × `cfg_div` + 2), where P is 1 when parity is used and 0 otherwise.
- R6: The receiver re-times `rxd` through a two-flop synchronizer. It accepts a start only when the line is still low at the eighth oversample after the falling edge, so a low pulse of two ticks or less produces no byte.
- R7: A received byte appears on `rx_data` with `rx_valid` high. `rx_valid` stays high until a clock with `rx_ack` high.
- R8: `err_par` is set when the received parity bit disagrees with the mode in `cfg_par`. It stays set until `err_clr` is pulsed.
- R9: `err_frm` is set when the stop bit samples low. It stays set until `err_clr` is pulsed.
- R10: `err_ovr` is set when a byte completes while the previous byte is still unacknowledged. The new byte replaces the old one, and the flag stays set until `err_clr` is pulsed.
- R11: A change of `cfg_div` reloads the divider at once, so the next frame uses the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 16 | Rate divisor, 0 disables the port |
| cfg_par | input | 3 | Parity mode, encoded as in R3 |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte waiting for acknowledge |
| rx_ack | input | 1 | Consume the waiting byte |
| err_clr | input | 1 | Clear all sticky error flags |
| err_par | output | 1 | Sticky parity error |
| err_frm | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun error |

## Verification
The assertions check properties that must hold on every clock:
- the tick spacing of the rate generator;
- an idle `txd` while the port is disabled;
- `tx_ready` dropping after each handshake;
- `rx_valid` holding until acknowledged;
- the stickiness of the error flags;
- overrun rising only while a byte is pending.

Only the bench's scenarios can show the following:
- the exact bit period;
- the bit order and each parity mode on the line;
- back-to-back spacing;
- rejection of a short start glitch;
- the response to a changed divisor.

// File: rtl/uart_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the serial transceiver.
// Assumes characters of a fixed eight bits; parity codes 5..7 behave as none.
package uart_pkg;

    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_EVEN = 3'd1,
        PAR_ODD  = 3'd2,
        PAR_ZERO = 3'd3,
        PAR_ONE  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } frm_state_e;

    // True when the mode inserts a parity bit
    function automatic logic par_used(input logic [2:0] mode);
        return (mode >= 3'd1) && (mode <= 3'd4);
    endfunction

    // Parity bit value for a data byte under a mode
    function automatic logic par_value(input logic [2:0] mode, input logic [7:0] d);
        case (mode)
            3'd1:    return ^d;
            3'd2:    return ~^d;
            3'd4:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_baud.sv
`timescale 1ns/1ps
// Shared oversampling tick generator: one tick every cfg_div clocks.
// Assumes a zero divisor means disabled. A divisor change reloads the count at once.
module uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             en,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;
    logic             changed;

    assign en      = (cfg_div != '0);
    assign changed = (cfg_div != div_q);
    assign tick    = en && !changed && (cnt == '0);

    // Down-counter that reloads on wrap or on a divisor change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt   <= '0;
        end else begin
            div_q <= cfg_div;
            if (!en)
                cnt <= '0;
            else if (changed || cnt == '0)
                cnt <= cfg_div - 1'b1;
            else
                cnt <= cnt - 1'b1;
        end
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_div > 1 && $stable(cfg_div)) |=> !tick);

endmodule

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
// Frame transmitter: start bit, eight data bits LSB first, optional parity, stop bit.
// Assumes cfg_par is captured with the byte. Disabling forces the idle state.
module uart_tx
    import uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [2:0]        par_mode,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);

    frm_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              use_par;
    logic              bit_end;

    assign bit_end  = tick && (cnt == CNT_W'(OSR - 1));
    assign tx_ready = en && (state == ST_IDLE);

    // Frame sequencer advancing one bit per OSR ticks
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
            use_par <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (tx_valid) begin
                shreg   <= tx_data;
                pbit    <= par_value(par_mode, tx_data);
                use_par <= par_used(par_mode);
                cnt     <= '0;
                state   <= ST_START;
            end
        end else if (tick) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
            if (bit_end) begin
                case (state)
                    ST_START: begin
                        idx   <= '0;
                        state <= ST_DATA;
                    end
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        idx   <= idx + 1'b1;
                        if (idx == IDX_W'(DATA_W - 1))
                            state <= use_par ? ST_PAR : ST_STOP;
                    end
                    ST_PAR:  state <= ST_STOP;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Line level chosen by the current frame position
    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = pbit;
            default:  txd = 1'b1;
        endcase
    end

    // R2
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> txd);
    // R4
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

endmodule

// File: rtl/uart_rx.sv
`timescale 1ns/1ps
// Frame receiver with two-flop synchronizer, mid-bit sampling and sticky error flags.
// Assumes cfg_par is stable during a frame. Disabling holds the sequencer idle.
module uart_rx
    import uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [2:0]        par_mode,
    input  logic              rxd,
    input  logic              rx_ack,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_par,
    output logic              err_frm,
    output logic              err_ovr
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int CONF  = OSR / 2 - 2;

    logic              rx_m, rx_s, last_hi;
    frm_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bad, frm_bad, done;
    logic              bit_end;

    assign bit_end = tick && (cnt == CNT_W'(OSR - 1));

    // Two-flop synchronizer and previous-sample tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m    <= 1'b1;
            rx_s    <= 1'b1;
            last_hi <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
            if (tick) last_hi <= rx_s;
        end
    end

    // Receive sequencer: edge detect, start confirm, mid-bit sampling
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_bad <= 1'b0;
            frm_bad <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (tick && !rx_s && last_hi) begin
                    cnt   <= '0;
                    state <= ST_START;
                end
                ST_START: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(CONF)) begin
                        cnt     <= '0;
                        idx     <= '0;
                        par_bad <= 1'b0;
                        state   <= rx_s ? ST_IDLE : ST_DATA;
                    end
                end
                default: if (tick) begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) begin
                        if (state == ST_DATA) begin
                            shreg <= {rx_s, shreg[DATA_W-1:1]};
                            idx   <= idx + 1'b1;
                            if (idx == IDX_W'(DATA_W - 1))
                                state <= par_used(par_mode) ? ST_PAR : ST_STOP;
                        end else if (state == ST_PAR) begin
                            par_bad <= (rx_s != par_value(par_mode, shreg));
                            state   <= ST_STOP;
                        end else begin
                            frm_bad <= !rx_s;
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Output holding register and sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            err_par  <= 1'b0;
            err_frm  <= 1'b0;
            err_ovr  <= 1'b0;
        end else begin
            if (done) begin
                rx_data  <= shreg;
                rx_valid <= 1'b1;
            end else if (rx_ack) begin
                rx_valid <= 1'b0;
            end
            if (done && par_bad)                   err_par <= 1'b1;
            else if (err_clr)                      err_par <= 1'b0;
            if (done && frm_bad)                   err_frm <= 1'b1;
            else if (err_clr)                      err_frm <= 1'b0;
            if (done && rx_valid && !rx_ack)       err_ovr <= 1'b1;
            else if (err_clr)                      err_ovr <= 1'b0;
        end
    end

    // R7
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ack) |=> rx_valid);
    // R8
    par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_par && !err_clr) |=> err_par);
    // R9
    frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frm && !err_clr) |=> err_frm);
    // R10
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> $past(rx_valid));

endmodule

// File: rtl/uart_xcvr.sv
`timescale 1ns/1ps
// Top of the serial transceiver: one shared tick generator feeding independent
// transmit and receive paths. Assumes synchronous active-low reset on clk.
module uart_xcvr #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [2:0]        cfg_par,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ack,
    input  logic              err_clr,
    output logic              err_par,
    output logic              err_frm,
    output logic              err_ovr
);
    logic en, tick;

    uart_baud #(.DIV_W(DIV_W)) i_baud (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .en(en), .tick(tick)
    );

    uart_tx #(.DATA_W(DATA_W), .OSR(OSR)) i_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .par_mode(cfg_par),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd)
    );

    uart_rx #(.DATA_W(DATA_W), .OSR(OSR)) i_rx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .par_mode(cfg_par),
        .rxd(rxd), .rx_ack(rx_ack), .err_clr(err_clr), .rx_data(rx_data),
        .rx_valid(rx_valid), .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr)
    );

endmodule

// File: tb/test_uart_xcvr.sv
`timescale 1ns/1ps
// Directed bench for the serial transceiver; each task checks its own scenario.
module test_uart_xcvr;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_div;
    logic [2:0]  cfg_par;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_ready, txd, rxd;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_ack, err_clr, err_par, err_frm, err_ovr;

    int      n_chk = 0;
    int      n_bad = 0;
    longint  cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_xcvr i_uart_xcvr (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_par(cfg_par),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack),
        .err_clr(err_clr), .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_pbit(input int pm, input logic [7:0] d);
        case (pm)
            1:       return ^d;
            2:       return ~^d;
            4:       return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit exp_puse(input int pm);
        return pm >= 1 && pm <= 4;
    endfunction

    task automatic wait_txd(input logic v);
        @(negedge clk);
        while (txd !== v) @(negedge clk);
    endtask

    task automatic tx_push(input logic [7:0] d);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); rx_ack = 1'b1;
        @(negedge clk); rx_ack = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic rx_send(input int div, input int pm, input logic [7:0] d,
                           input bit flip_par, input bit bad_stop);
        int per;
        per = 16 * div;
        @(negedge clk); rxd = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (per) @(negedge clk);
        end
        if (exp_puse(pm)) begin
            rxd = exp_pbit(pm, d) ^ flip_par;
            repeat (per) @(negedge clk);
        end
        rxd = !bad_stop;
        repeat (per) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * per) @(negedge clk);
    endtask

    // R2: outputs at reset while disabled
    task automatic t_reset();
        chk("R2 reset txd", txd, 1);
        chk("R2 reset tx_ready", tx_ready, 0);
        chk("R7 reset rx_valid", rx_valid, 0);
        chk("R8 reset flags", {err_par, err_frm, err_ovr}, 0);
    endtask

    // R2: zero divisor holds both directions inactive
    task automatic t_disabled();
        int txd_low = 0;
        cfg_div = 16'd0;
        @(negedge clk); tx_data = 8'h5A; tx_valid = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!txd || tx_ready) txd_low++;
        end
        tx_valid = 1'b0;
        chk("R2 tx idle while off", txd_low, 0);
        rx_send(2, 0, 8'h66, 0, 0);
        chk("R2 rx ignores line", rx_valid, 0);
        chk("R2 no flags while off", {err_par, err_frm, err_ovr}, 0);
    endtask

    // R3/R4: one frame on the line with given divisor and parity mode
    task automatic t_tx(input int div, input int pm, input logic [7:0] d);
        cfg_div = 16'(div); cfg_par = 3'(pm);
        repeat (3) @(negedge clk);
        tx_push(d);
        chk("R4 ready low after accept", tx_ready, 0);
        repeat (8 * div - 1) @(negedge clk);
        chk("R3 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (16 * div) @(negedge clk);
            chk($sformatf("R3 data bit %0d of %02h", i, d), txd, d[i]);
        end
        if (exp_puse(pm)) begin
            repeat (16 * div) @(negedge clk);
            chk($sformatf("R3 parity mode %0d", pm), txd, exp_pbit(pm, d));
        end
        repeat (16 * div) @(negedge clk);
        chk("R3 stop bit", txd, 1);
        chk("R4 ready low in stop", tx_ready, 0);
        wait_txd(1);
        repeat (16 * div) @(negedge clk);
        chk("R4 ready after frame", tx_ready, 1);
    endtask

    // R1/R11: exact bit period from edges of an alternating byte
    task automatic t_rate(input int div, input string tag);
        longint ta, tb;
        cfg_div = 16'(div); cfg_par = 3'd0;
        repeat (3) @(negedge clk);
        tx_push(8'h55);
        wait_txd(1);
        wait_txd(0); ta = cyc;
        wait_txd(1); tb = cyc;
        chk(tag, tb - ta, 16 * div);
        repeat (200 * div) @(negedge clk);
    endtask

    // R5: back-to-back frames with no guard time
    task automatic t_b2b(input int div);
        longint t1, t2, dlt;
        cfg_div = 16'(div); cfg_par = 3'd0;
        repeat (3) @(negedge clk);
        tx_push(8'hC3);
        t1 = cyc;
        tx_push(8'h3C);
        t2 = cyc;
        dlt = t2 - t1 - 160 * div;
        if (dlt < 0) dlt = -dlt;
        chk("R5 start spacing within tolerance", dlt <= 2 * div + 2, 1);
        repeat (200 * div) @(negedge clk);
    endtask

    // R7/R8: good frame received, acknowledged
    task automatic t_rx_ok(input int div, input int pm, input logic [7:0] d);
        cfg_div = 16'(div); cfg_par = 3'(pm);
        repeat (3) @(negedge clk);
        rx_send(div, pm, d, 0, 0);
        chk("R7 rx_valid set", rx_valid, 1);
        chk("R7 rx_data", rx_data, d);
        chk("R8 no parity error", err_par, 0);
        chk("R9 no framing error", err_frm, 0);
        repeat (10) @(negedge clk);
        chk("R7 rx_valid held", rx_valid, 1);
        pulse_ack();
        chk("R7 rx_valid cleared", rx_valid, 0);
    endtask

    // R8: parity mismatch sticky until cleared
    task automatic t_perr();
        cfg_div = 16'd2; cfg_par = 3'd1;
        repeat (3) @(negedge clk);
        rx_send(2, 1, 8'h96, 1, 0);
        chk("R8 parity error set", err_par, 1);
        chk("R8 data still delivered", rx_data, 8'h96);
        pulse_ack();
        repeat (20) @(negedge clk);
        chk("R8 parity error sticky", err_par, 1);
        pulse_clr();
        chk("R8 parity error cleared", err_par, 0);
    endtask

    // R9: low stop bit
    task automatic t_ferr();
        cfg_div = 16'd2; cfg_par = 3'd0;
        repeat (3) @(negedge clk);
        rx_send(2, 0, 8'h0F, 0, 1);
        chk("R9 framing error set", err_frm, 1);
        pulse_ack();
        repeat (20) @(negedge clk);
        chk("R9 framing error sticky", err_frm, 1);
        pulse_clr();
        chk("R9 framing error cleared", err_frm, 0);
    endtask

    // R10: second byte without acknowledge
    task automatic t_ovr();
        cfg_div = 16'd2; cfg_par = 3'd0;
        repeat (3) @(negedge clk);
        rx_send(2, 0, 8'h11, 0, 0);
        chk("R10 no overrun after first", err_ovr, 0);
        rx_send(2, 0, 8'h22, 0, 0);
        chk("R10 overrun set", err_ovr, 1);
        chk("R10 newer byte kept", rx_data, 8'h22);
        pulse_ack();
        pulse_clr();
        chk("R10 overrun cleared", err_ovr, 0);
    endtask

    // R6: short low pulse is not a start bit
    task automatic t_glitch();
        cfg_div = 16'd2; cfg_par = 3'd0;
        repeat (3) @(negedge clk);
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (400) @(negedge clk);
        chk("R6 glitch rejected", rx_valid, 0);
        chk("R6 no flags from glitch", {err_par, err_frm, err_ovr}, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_div = 16'd0; cfg_par = 3'd0; tx_data = 8'h00;
        tx_valid = 1'b0; rxd = 1'b1; rx_ack = 1'b0; err_clr = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_disabled();
        t_tx(1, 0, 8'hA5);
        t_tx(3, 1, 8'h37);
        t_tx(3, 2, 8'h37);
        t_tx(2, 3, 8'hFF);
        t_tx(2, 4, 8'h00);
        t_tx(2, 6, 8'h81);
        t_rate(3, "R1 bit period at divisor 3");
        t_rate(5, "R11 bit period after change to 5");
        t_b2b(2);
        t_rx_ok(2, 0, 8'h3C);
        t_rx_ok(3, 2, 8'h81);
        t_rx_ok(1, 4, 8'hE7);
        t_perr();
        t_ferr();
        t_ovr();
        t_glitch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule